// File: doc/BRIEF.md
# Two-Stage Baud Tick Generator

This block turns a free-running reference clock into the two timing strobes a serial transmitter and receiver need. A selectable fixed prescaler comes first: it either passes every reference cycle through or keeps one cycle in eight. A wide sample divisor then counts those selected cycles and produces a sample-rate strobe. A narrow bit divisor counts sample strobes and produces a bit-boundary strobe. Both strobes are one-cycle enables in the reference clock domain, not derived clocks.

The resulting bit rate is the selected clock rate divided by `clk_div * (bit_div + 1)`. Software chooses the divisor values and the shift logic consumes the strobes; both lie outside this block. Whenever a divisor or the prescale selection changes, the controlling logic pulses `restart`. This brings every counter back to zero, so the first strobe arrives one full period later.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `sample_en` and `bit_en` are 0.
- R2: With `clk_sel` = 0 and `clk_div` = N ≥ 1, `sample_en` is 1 exactly in cycles N, 2N, 3N, … counted in clock edges after the last reset or restart edge.
- R3: With `clk_sel` = 1 the prescaler keeps one reference cycle in eight. `sample_en` is then 1 exactly every 8·N edges after the last reset or restart edge, and never in two consecutive cycles.
- R4: With `clk_div` = 0, `sample_en` and `bit_en` stay 0 for every value of the other inputs.
- R5: With `clk_sel` = 0 and `clk_div` = 1, `sample_en` is 1 in every cycle after the first edge following reset or restart.
- R6: `bit_en` is 1 exactly on every (`bit_div` + 1)-th `sample_en` pulse counted since reset or restart, and only in a cycle where `sample_en` is also 1. With `bit_div` = 0, `bit_en` follows `sample_en`.
- R7: A clock edge with `restart` = 1 clears the prescaler and both divisor counters. Both outputs are 0 in the cycle after it, and timing restarts from that edge as in R2/R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 1 | 1 = prescale the reference clock by 8, 0 = use it directly |
| clk_div | input | 16 | Sample divisor; 0 stops sample strobes |
| bit_div | input | 8 | Bit divisor; a bit spans bit_div + 1 samples |
| restart | input | 1 | Synchronous strobe that zeroes all counters |
| sample_en | output | 1 | One-cycle sample-rate enable |
| bit_en | output | 1 | One-cycle bit-boundary enable |

## Verification
The bench builds the block with its default parameters: a 16-bit sample divisor, an 8-bit bit divisor and a divide-by-8 prescaler. It drives small divisor values so that several full bit periods fit in each phase, both with and without the prescaler. This covers the wrap of each counter, divisor values of 0 and 1, and a bit divisor of 0. Restart pulses are inserted in the middle of a bit period, both single and held for several cycles. This shows that the timing realigns to the release edge instead of continuing the old phase.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned BG_CD_W     = 16;
  localparam int unsigned BG_BD_W     = 8;
  localparam int unsigned BG_PRE_LOG2 = 3;
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int unsigned LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic sel,
  output logic tick
);
  generate
    if (LOG2 == 0) begin : g_none
      assign tick = 1'b1;
    end else begin : g_cnt
      logic [LOG2-1:0] pcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pcnt <= '0;
        else if (clear) pcnt <= '0;
        else            pcnt <= pcnt + 1'b1;
      end
      // One selected cycle per wrap when prescaling, else every cycle
      assign tick = sel ? (pcnt == '1) : 1'b1;
    end
  endgenerate
endmodule

// File: rtl/baud_stage.sv
module baud_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         fire
);
  logic [W-1:0] cnt;

  // >= keeps the counter from running to full scale if limit shrinks
  assign fire = step && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= fire ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int unsigned CD_W     = BG_CD_W,
  parameter int unsigned BD_W     = BG_BD_W,
  parameter int unsigned PRE_LOG2 = BG_PRE_LOG2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_sel,
  input  logic [CD_W-1:0] clk_div,
  input  logic [BD_W-1:0] bit_div,
  input  logic            restart,
  output logic            sample_en,
  output logic            bit_en
);
  logic            pre_tick;
  logic            smp_step;
  logic            smp_fire;
  logic            bit_fire;
  logic [CD_W-1:0] cd_limit;

  baud_prescale #(.LOG2(PRE_LOG2)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart),
    .sel   (clk_sel),
    .tick  (pre_tick)
  );

  assign cd_limit = clk_div - 1'b1;
  assign smp_step = pre_tick && (clk_div != '0);

  baud_stage #(.W(CD_W)) u_smp (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart),
    .step  (smp_step),
    .limit (cd_limit),
    .fire  (smp_fire)
  );

  baud_stage #(.W(BD_W)) u_bit (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (restart),
    .step  (smp_fire),
    .limit (bit_div),
    .fire  (bit_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_en <= 1'b0;
      bit_en    <= 1'b0;
    end else if (restart) begin
      sample_en <= 1'b0;
      bit_en    <= 1'b0;
    end else begin
      sample_en <= smp_fire;
      bit_en    <= bit_fire;
    end
  end
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int unsigned CD_W = 16,
  parameter int unsigned BD_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clk_sel,
  input logic [CD_W-1:0] clk_div,
  input logic [BD_W-1:0] bit_div,
  input logic            restart,
  input logic            sample_en,
  input logic            bit_en
);
  // R6
  bit_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> sample_en);

  // R7
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!sample_en && !bit_en));

  // R4
  zero_div_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clk_div) == '0) |-> (!sample_en && !bit_en));

  // R3
  prescale_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && clk_sel && $past(clk_sel)) |=> !sample_en);

  logic unused_bd;
  assign unused_bd = ^bit_div;
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.CD_W(CD_W), .BD_W(BD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_sel   (clk_sel),
  .clk_div   (clk_div),
  .bit_div   (bit_div),
  .restart   (restart),
  .sample_en (sample_en),
  .bit_en    (bit_en)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_sel = 1'b0;
  logic [15:0] clk_div = 16'd0;
  logic [7:0]  bit_div = 8'd0;
  logic        restart = 1'b0;
  logic        sample_en, bit_en;

  int    n_checks = 0;
  int    n_fail   = 0;
  string tag      = "R1";
  longint t_edges = 0;
  logic  exp_s = 1'b0, exp_b = 1'b0;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_tick_gen u_dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .clk_div(clk_div),
    .bit_div(bit_div), .restart(restart), .sample_en(sample_en), .bit_en(bit_en)
  );

  // Behavioural model: edges elapsed since the last reset/restart edge
  always @(posedge clk) begin
    longint per, bper;
    if (!rst_n || restart) t_edges = 0;
    else                   t_edges = t_edges + 1;
    per  = (clk_sel ? 8 : 1) * longint'(clk_div);
    bper = per * (longint'(bit_div) + 1);
    exp_s = (per != 0) && (t_edges > 0) && (t_edges % per == 0);
    exp_b = exp_s && (t_edges % bper == 0);
  end

  task automatic check_now();
    n_checks++;
    if (sample_en !== exp_s || bit_en !== exp_b) begin
      n_fail++;
      $display("FAIL %s t=%0t: sample_en=%b bit_en=%b expected %b %b",
               tag, $time, sample_en, bit_en, exp_s, exp_b);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
    end
  endtask

  task automatic phase(input string t, input logic sel, input int cd,
                       input int bd, input int n);
    @(negedge clk);
    tag = t; clk_sel = sel; clk_div = 16'(cd); bit_div = 8'(bd); restart = 1'b1;
    @(negedge clk);
    check_now();
    restart = 1'b0;
    run(n);
  endtask

  initial begin
    // R1: held in reset, then first cycle out of reset
    clk_div = 16'd1; bit_div = 8'd0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); check_now(); end
    rst_n = 1'b1;
    @(negedge clk); check_now();
    run(3);

    phase("R2", 1'b0, 4, 3, 60);
    phase("R2", 1'b0, 3, 2, 40);
    phase("R5", 1'b0, 1, 2, 20);
    phase("R6", 1'b0, 1, 0, 12);
    phase("R6", 1'b0, 2, 5, 40);
    phase("R3", 1'b1, 1, 1, 40);
    phase("R3", 1'b1, 5, 4, 420);
    phase("R3", 1'b1, 2, 0, 60);
    phase("R4", 1'b0, 0, 0, 50);
    phase("R4", 1'b1, 0, 3, 50);

    // R7: restart pulses in the middle of a bit period
    phase("R7", 1'b0, 3, 3, 17);
    tag = "R7"; restart = 1'b1;
    @(negedge clk); check_now();
    restart = 1'b0;
    run(30);
    restart = 1'b1;
    run(5);
    restart = 1'b0;
    run(40);
    phase("R7", 1'b1, 2, 1, 21);
    restart = 1'b1;
    @(negedge clk); check_now();
    restart = 1'b0;
    run(70);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule